// File: doc/BRIEF.md
# Multi-Channel Countdown Interval Timer

This block is a programmable interval timer attached to an APB slave port. It holds a parameterised number of independent channels. Each channel has a control register, a reload register and a live counter register. A channel can run as one 32-bit down-counter, as two 16-bit down-counters or as four 8-bit down-counters. Every sub-timer has its own enable bit and its own interrupt status bit. A sub-timer reloads itself each time it expires, so it fires periodically with no software action.

Each channel counts either on every APB clock or on rising edges of a shared external tick input. That input passes through a two-flop synchroniser before its edges are detected. The interrupt status bits are cleared by writing 1 to them, and they are gated by an interrupt-enable mask. The gated bits are ORed into one interrupt line.

Top module: `pit_apb_timer`

## Requirements
- R1: After reset, offset 0x00 reads the ID_VALUE parameter and offset 0x10 reads NUM_CH. Offsets 0x04, 0x08 and 0x0C and every other unmapped offset read zero. All writable registers and all counters reset to zero.
- R2: Channel c decodes its control register at 0x20+0x10*c, its reload register at 0x24+0x10*c and its counter register at 0x28+0x10*c. Control bits [3:0] and all 32 reload bits read back as written.
- R3: Offset 0x1C holds the enable bits. The bit for sub-timer i of channel c is bit 4*c+i, and the same bit position is used in the interrupt-enable register (0x14) and the status register (0x18). When an enable bit goes from 0 to 1, the sub-timer loads its counter field from its reload field. While the enable bit is 0, the count is frozen.
- R4: When control[2:0]=1, the channel is one 32-bit timer controlled by enable bit 4*c. On each count step it decrements. A step taken while the count is 0 instead reloads the count and sets status bit 4*c. The period is therefore reload+1 steps. With control bit 3 set, a step happens on every APB clock.
- R5: When control[2:0]=2, sub-timer 0 uses bits [15:0] and sub-timer 1 uses bits [31:16] of the reload and counter registers. Each half counts, reloads and sets its own status bit on its own.
- R6: When control[2:0]=3, sub-timer i uses byte i (bits [8i+7:8i]) and behaves as in R5 at 8-bit width.
- R7: Any other value of control[2:0] leaves the channel idle. It neither counts nor reloads, including on an enable rising edge.
- R8: With control bit 3 clear, a step is one rising edge of ext_tick_in after a two-flop synchroniser. The count changes on the third APB clock edge after the input rises.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R10: The irq output is high exactly when some status bit and its matching interrupt-enable bit are both 1.
- R11: A write to a counter register replaces the whole live count at once. This takes priority over loading and counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| ext_tick_in | input | 1 | Asynchronous external count clock |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bound checker checks a set of rules on every cycle:
- a status bit is never lost unless a write-1 clear was aimed at it;
- every expiry leaves its status bit set;
- irq stays low when no source is enabled, and is high only when some status bit is set;
- a channel with all enables clear never changes its count unless software writes it;
- unmapped offsets and the configuration word always read correctly.

Other behaviours can only be shown by the bench's scenarios:
- the exact count values after a given number of external edges;
- the 16-bit and 8-bit lane splitting and independent reloads;
- reload when an enable goes high;
- the idle modes;
- the cycle at which an APB-clocked count first decrements.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int PIT_DW    = 32;
  localparam int PIT_LANES = 4;

  localparam logic [2:0] MODE_W32 = 3'd1;
  localparam logic [2:0] MODE_W16 = 3'd2;
  localparam logic [2:0] MODE_W8  = 3'd3;

  localparam int OFS_ID    = 'h00;
  localparam int OFS_CFG   = 'h10;
  localparam int OFS_INTEN = 'h14;
  localparam int OFS_STS   = 'h18;
  localparam int OFS_CHEN  = 'h1C;
  localparam int CH_BASE   = 'h20;
  localparam int CH_STRIDE = 'h10;
  localparam int CH_CTL    = 'h0;
  localparam int CH_REL    = 'h4;
  localparam int CH_CNT    = 'h8;

  typedef struct packed {
    logic       use_pclk;
    logic [2:0] mode;
  } pit_ctl_t;
endpackage

// File: rtl/pit_ext_tick.sv
module pit_ext_tick #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic tick
);
  logic [STAGES:0] sh_q, sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], ext_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  // one-cycle pulse on a synchronised rising edge
  assign tick = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int W     = PIT_DW,
  parameter int LANES = PIT_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pit_ctl_t         ctl,
  input  logic [LANES-1:0] en,
  input  logic             ext_tick,
  input  logic [W-1:0]     reload,
  input  logic             cnt_wr,
  input  logic [W-1:0]     cnt_wdata,
  output logic [W-1:0]     cnt,
  output logic [LANES-1:0] expire
);
  localparam int HW = W / 2;
  localparam int QW = W / LANES;

  logic [W-1:0]     cnt_q, cnt_d;
  logic [LANES-1:0] en_q, rise;
  logic             step;

  always_comb begin
    step   = ctl.use_pclk | ext_tick;
    rise   = en & ~en_q;
    cnt_d  = cnt_q;
    expire = '0;
    case (ctl.mode)
      MODE_W32: begin
        if (rise[0]) begin
          cnt_d = reload;
        end else if (en[0] && step) begin
          if (cnt_q == '0) begin
            cnt_d     = reload;
            expire[0] = 1'b1;
          end else begin
            cnt_d = cnt_q - W'(1);
          end
        end
      end
      MODE_W16: begin
        for (int i = 0; i < 2; i++) begin
          if (rise[i]) begin
            cnt_d[i*HW +: HW] = reload[i*HW +: HW];
          end else if (en[i] && step) begin
            if (cnt_q[i*HW +: HW] == '0) begin
              cnt_d[i*HW +: HW] = reload[i*HW +: HW];
              expire[i]         = 1'b1;
            end else begin
              cnt_d[i*HW +: HW] = cnt_q[i*HW +: HW] - HW'(1);
            end
          end
        end
      end
      MODE_W8: begin
        for (int i = 0; i < LANES; i++) begin
          if (rise[i]) begin
            cnt_d[i*QW +: QW] = reload[i*QW +: QW];
          end else if (en[i] && step) begin
            if (cnt_q[i*QW +: QW] == '0) begin
              cnt_d[i*QW +: QW] = reload[i*QW +: QW];
              expire[i]         = 1'b1;
            end else begin
              cnt_d[i*QW +: QW] = cnt_q[i*QW +: QW] - QW'(1);
            end
          end
        end
      end
      default: ;
    endcase
    if (cnt_wr) cnt_d = cnt_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      en_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      en_q  <= en;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pit_apb_timer.sv
module pit_apb_timer
  import pit_pkg::*;
#(
  parameter int          NUM_CH   = 2,
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h0A71_0100
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              ext_tick_in,
  output logic              irq
);
  localparam int DW = PIT_DW;
  localparam int TB = PIT_LANES * NUM_CH;

  logic [1:0] rst_q;
  logic       rst_n_s;

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rst_q <= '0;
    else          rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_n_s = rst_q[1];

  logic              wr_en;
  logic [TB-1:0]     inten_q, inten_d, sts_q, sts_d, chen_q, chen_d, clr, exp_all;
  pit_ctl_t          ctl_q [NUM_CH];
  pit_ctl_t          ctl_d [NUM_CH];
  logic [DW-1:0]     rel_q [NUM_CH];
  logic [DW-1:0]     rel_d [NUM_CH];
  logic [DW-1:0]     cnt_w [NUM_CH];
  logic [NUM_CH-1:0] ctl_we, rel_we, cnt_we;
  logic [NUM_CH*DW-1:0] cnt_all;
  logic              ext_tick;

  assign wr_en = psel & penable & pwrite;

  pit_ext_tick #(.STAGES(2)) u_sync (
    .clk(pclk), .rst_n(rst_n_s), .ext_in(ext_tick_in), .tick(ext_tick)
  );

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ctl_we[c] = wr_en && (paddr == ADDR_W'(CH_BASE + CH_STRIDE*c + CH_CTL));
      rel_we[c] = wr_en && (paddr == ADDR_W'(CH_BASE + CH_STRIDE*c + CH_REL));
      cnt_we[c] = wr_en && (paddr == ADDR_W'(CH_BASE + CH_STRIDE*c + CH_CNT));
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pit_channel #(.W(DW), .LANES(PIT_LANES)) u_ch (
      .clk(pclk), .rst_n(rst_n_s), .ctl(ctl_q[c]),
      .en(chen_q[c*PIT_LANES +: PIT_LANES]), .ext_tick(ext_tick),
      .reload(rel_q[c]), .cnt_wr(cnt_we[c]), .cnt_wdata(pwdata),
      .cnt(cnt_w[c]), .expire(exp_all[c*PIT_LANES +: PIT_LANES])
    );
    assign cnt_all[c*DW +: DW] = cnt_w[c];
  end

  // next state
  always_comb begin
    inten_d = inten_q;
    chen_d  = chen_q;
    if (wr_en && paddr == ADDR_W'(OFS_INTEN)) inten_d = pwdata[TB-1:0];
    if (wr_en && paddr == ADDR_W'(OFS_CHEN))  chen_d  = pwdata[TB-1:0];
    clr   = (wr_en && paddr == ADDR_W'(OFS_STS)) ? pwdata[TB-1:0] : '0;
    sts_d = (sts_q & ~clr) | exp_all;
    for (int c = 0; c < NUM_CH; c++) begin
      ctl_d[c] = ctl_we[c] ? pit_ctl_t'(pwdata[3:0]) : ctl_q[c];
      rel_d[c] = rel_we[c] ? pwdata : rel_q[c];
    end
  end

  always_ff @(posedge pclk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      inten_q <= '0;
      chen_q  <= '0;
      sts_q   <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        ctl_q[c] <= '0;
        rel_q[c] <= '0;
      end
    end else begin
      inten_q <= inten_d;
      chen_q  <= chen_d;
      sts_q   <= sts_d;
      for (int c = 0; c < NUM_CH; c++) begin
        ctl_q[c] <= ctl_d[c];
        rel_q[c] <= rel_d[c];
      end
    end
  end

  // read mux
  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (paddr == ADDR_W'(OFS_ID))    prdata = ID_VALUE;
      if (paddr == ADDR_W'(OFS_CFG))   prdata = DW'(NUM_CH);
      if (paddr == ADDR_W'(OFS_INTEN)) prdata = DW'(inten_q);
      if (paddr == ADDR_W'(OFS_STS))   prdata = DW'(sts_q);
      if (paddr == ADDR_W'(OFS_CHEN))  prdata = DW'(chen_q);
      for (int c = 0; c < NUM_CH; c++) begin
        if (paddr == ADDR_W'(CH_BASE + CH_STRIDE*c + CH_CTL)) prdata = DW'({ctl_q[c]});
        if (paddr == ADDR_W'(CH_BASE + CH_STRIDE*c + CH_REL)) prdata = rel_q[c];
        if (paddr == ADDR_W'(CH_BASE + CH_STRIDE*c + CH_CNT)) prdata = cnt_w[c];
      end
    end
  end

  assign irq = |(sts_q & inten_q);
endmodule

// File: rtl/pit_apb_timer_chk.sv
module pit_apb_timer_chk
  import pit_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  localparam int TB = PIT_LANES * NUM_CH
) (
  input logic                   pclk,
  input logic                   presetn,
  input logic                   psel,
  input logic                   penable,
  input logic                   pwrite,
  input logic [ADDR_W-1:0]      paddr,
  input logic [TB-1:0]          wdata_lo,
  input logic [31:0]            prdata,
  input logic                   irq,
  input logic [TB-1:0]          inten,
  input logic [TB-1:0]          sts,
  input logic [TB-1:0]          chen,
  input logic [TB-1:0]          exp_all,
  input logic [NUM_CH-1:0]      cnt_we,
  input logic [NUM_CH*32-1:0]   cnt_all
);
  logic [TB-1:0] clr_req;
  logic          rd_gap;

  always_comb begin
    clr_req = (psel && penable && pwrite && paddr == ADDR_W'(OFS_STS)) ? wdata_lo : '0;
    rd_gap  = psel && !pwrite &&
              (paddr == ADDR_W'(4) || paddr == ADDR_W'(8) || paddr == ADDR_W'('hC));
  end

  // R9: a set status bit survives unless a write-1 clear targeted it
  p_sts_hold_r9: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> ((($past(sts) & ~$past(clr_req)) & ~sts) == '0));

  // R4: every expiry is recorded in status
  p_sts_set_r4: assert property (@(posedge pclk) disable iff (!presetn)
    1'b1 |=> ((sts & $past(exp_all)) == $past(exp_all)));

  // R10: no interrupt without an enabled source
  p_irq_quiet_r10: assert property (@(posedge pclk) disable iff (!presetn)
    (inten == '0) |-> !irq);

  p_irq_src_r10: assert property (@(posedge pclk) disable iff (!presetn)
    irq |-> (sts != '0));

  // R1: unmapped words read zero; configuration word reports channels
  p_unmapped_r1: assert property (@(posedge pclk) disable iff (!presetn)
    rd_gap |-> (prdata == '0));

  p_cfg_r1: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr == ADDR_W'(OFS_CFG)) |-> (prdata == 32'(NUM_CH)));

  // R3: a channel with every enable clear holds its count
  for (genvar c = 0; c < NUM_CH; c++) begin : g_frz
    p_frozen_r3: assert property (@(posedge pclk) disable iff (!presetn)
      (chen[c*PIT_LANES +: PIT_LANES] == '0 && !cnt_we[c]) |=> $stable(cnt_all[c*32 +: 32]));
  end
endmodule

bind pit_apb_timer pit_apb_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .wdata_lo(pwdata[PIT_LANES*NUM_CH-1:0]), .prdata(prdata), .irq(irq),
  .inten(inten_q), .sts(sts_q), .chen(chen_q), .exp_all(exp_all),
  .cnt_we(cnt_we), .cnt_all(cnt_all)
);

// File: tb/tb_pit_apb_timer.sv
module tb_pit_apb_timer;
  localparam logic [31:0] IDV = 32'h0A71_0100;
  localparam logic [7:0] A_ID = 8'h00, A_CFG = 8'h10, A_IEN = 8'h14, A_STS = 8'h18,
                         A_CHEN = 8'h1C, A_CTL0 = 8'h20, A_REL0 = 8'h24, A_CNT0 = 8'h28,
                         A_CTL1 = 8'h30, A_REL1 = 8'h34, A_CNT1 = 8'h38;

  logic pclk = 1'b0, presetn = 1'b0, psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic ext_tick_in = 1'b0, irq, irq_probe = 1'b0;
  int tests = 0, fails = 0;
  bit done = 0;

  typedef struct { bit is_irq; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #5 pclk = ~pclk;

  pit_apb_timer #(.NUM_CH(2), .ADDR_W(8), .ID_VALUE(IDV)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .ext_tick_in(ext_tick_in), .irq(irq)
  );

  // monitor: pops expectations as results appear
  always @(negedge pclk) begin
    if ((psel && penable && !pwrite) || irq_probe) begin
      item_t it;
      logic [31:0] act;
      act = irq_probe ? {31'b0, irq} : prdata;
      tests++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty actual=%h expected=none", act);
      end else begin
        it = sb.pop_front();
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge pclk); #1; psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(posedge pclk); #1; penable = 1;
    @(posedge pclk); #1; psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic check_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.is_irq = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(posedge pclk); #1; psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(posedge pclk); #1; penable = 1;
    @(posedge pclk); #1; psel = 0; penable = 0;
  endtask

  task automatic check_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    @(posedge pclk); #1; irq_probe = 1;
    @(posedge pclk); #1; irq_probe = 0;
  endtask

  task automatic ext_pulses(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge pclk); #1; ext_tick_in = 1;
      repeat (4) @(posedge pclk);
      #1; ext_tick_in = 0;
      repeat (4) @(posedge pclk);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge pclk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog (all) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge pclk);
    #1; presetn = 1;
    repeat (4) @(posedge pclk);

    // reset state
    check_rd(A_ID,   IDV,   "R1 id");
    check_rd(A_CFG,  32'd2, "R1 cfg");
    check_rd(8'h04,  '0,    "R1 unmapped");
    check_rd(A_STS,  '0,    "R1 status reset");
    check_rd(A_CHEN, '0,    "R1 enable reset");
    check_rd(A_CNT0, '0,    "R1 counter reset");
    check_irq(1'b0,          "R10 reset irq");

    // layout and external clock counting
    apb_wr(A_CTL0, 32'h1);
    apb_wr(A_REL0, 32'd100);
    check_rd(A_CTL0, 32'h1,   "R2 ctl readback");
    check_rd(A_REL0, 32'd100, "R2 reload readback");
    apb_wr(A_CHEN, 32'h01);
    check_rd(A_CNT0, 32'd100, "R3 load on enable");
    ext_pulses(5);
    check_rd(A_CNT0, 32'd95,  "R8 external edges");

    // freeze and re-enable
    apb_wr(A_CHEN, 32'h00);
    ext_pulses(3);
    check_rd(A_CNT0, 32'd95,  "R3 frozen");
    apb_wr(A_CHEN, 32'h01);
    check_rd(A_CNT0, 32'd100, "R3 reload on re-enable");

    // direct write, expiry, status and irq
    apb_wr(A_CNT0, 32'd2);
    check_rd(A_CNT0, 32'd2,   "R11 counter write");
    ext_pulses(2);
    check_rd(A_CNT0, 32'd0,   "R4 reaches zero");
    check_rd(A_STS,  32'h0,   "R4 no flag at zero");
    ext_pulses(1);
    check_rd(A_CNT0, 32'd100, "R4 periodic reload");
    check_rd(A_STS,  32'h1,   "R4 status set");
    check_irq(1'b0,           "R10 masked");
    apb_wr(A_IEN, 32'h1);
    check_irq(1'b1,           "R10 enabled");
    apb_wr(A_STS, 32'h0);
    check_rd(A_STS,  32'h1,   "R9 write zero keeps");
    apb_wr(A_STS, 32'h1);
    check_rd(A_STS,  32'h0,   "R9 write one clears");
    check_irq(1'b0,           "R10 cleared");

    // 16-bit split on channel 1
    apb_wr(A_CTL1, 32'h2);
    apb_wr(A_REL1, 32'h0001_0003);
    apb_wr(A_CHEN, 32'h30);
    check_rd(A_CNT1, 32'h0001_0003, "R5 halves loaded");
    ext_pulses(2);
    check_rd(A_CNT1, 32'h0001_0001, "R5 halves independent");
    check_rd(A_STS,  32'h20,        "R5 upper half flag");
    apb_wr(A_STS, 32'h20);

    // 8-bit split on channel 1
    apb_wr(A_CHEN, 32'h00);
    apb_wr(A_CTL1, 32'h3);
    apb_wr(A_REL1, 32'h0403_0201);
    apb_wr(A_CHEN, 32'hF0);
    check_rd(A_CNT1, 32'h0403_0201, "R6 bytes loaded");
    ext_pulses(2);
    check_rd(A_CNT1, 32'h0201_0001, "R6 bytes independent");
    check_rd(A_STS,  32'h10,        "R6 byte0 flag");
    check_irq(1'b0,                 "R10 other bit masked");
    apb_wr(A_STS, 32'hFF);

    // idle mode
    apb_wr(A_CHEN, 32'h00);
    apb_wr(A_CTL1, 32'h0);
    apb_wr(A_CNT1, 32'h55);
    apb_wr(A_CHEN, 32'hF0);
    check_rd(A_CNT1, 32'h55, "R7 no load");
    ext_pulses(2);
    check_rd(A_CNT1, 32'h55, "R7 no count");
    check_rd(A_STS,  32'h0,  "R7 no flag");

    // APB clock counting: load at E+1, first step at E+2
    apb_wr(A_CHEN, 32'h00);
    apb_wr(A_CTL0, 32'h9);
    apb_wr(A_REL0, 32'd1000);
    apb_wr(A_CHEN, 32'h01);
    check_rd(A_CNT0, 32'd999, "R4 pclk step timing");
    apb_wr(A_CHEN, 32'h00);
    apb_wr(A_REL0, 32'd9);
    apb_wr(A_STS, 32'hFF);
    apb_wr(A_CHEN, 32'h01);
    repeat (40) @(posedge pclk);
    check_rd(A_STS, 32'h1, "R4 pclk periodic flag");
    check_irq(1'b1,        "R10 pclk irq");
    apb_wr(A_CHEN, 32'h00);
    apb_wr(A_STS, 32'h1);
    check_rd(A_STS, 32'h0, "R9 final clear");
    check_irq(1'b0,        "R10 final");

    repeat (4) @(posedge pclk);
    if (sb.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule